// File: doc/BRIEF.md
# Edge-Triggered GPIO Bank with Interrupts

A bank of 32 general-purpose pins behind a small memory-mapped register interface. Each pin has its own control word that picks its direction and which input transitions count as events. Output pins are driven from an output latch that software changes only through write-one-to-set and write-one-to-clear registers, so two agents can update different pins without a read-modify-write.

Input pins pass through a two-stage synchroniser. The synchronised value feeds an edge detector that can be set to rising, falling or both edges. A detected edge latches a per-pin interrupt status bit. Software clears status by writing ones. The single bank interrupt line is high while any status bit is set whose mask bit is clear. Masking is also controlled by separate set and clear registers. Only edges cause interrupts; there is no level-sensitive mode. An edge that arrives in the same cycle as a clear of its status bit is not lost. The register interface takes one access per cycle, and read data appears registered on the cycle after the read strobe.

Top module: `gpio_bank`

## Requirements
- R1: After reset every pin is an input (pin_oe all 0), pin_out is 0, all 32 mask bits read 1 at offset 0xA0, interrupt status at 0x80 reads 0, irq is low, and each control word reads 0x1.
- R2: The control word of pin n is at byte offset 0x100 + 4*n. Bit 0 is the direction (1 input, 0 output) and bits [4:3] are the trigger. It reads back with only bits 0, 3 and 4 kept, and pin_oe[n] is the inverse of bit 0.
- R3: Writing offset 0x40 sets each output latch bit written as 1 and leaves the others. The latch reads back at offset 0x00 and drives pin_out.
- R4: Writing offset 0x60 clears each output latch bit written as 1 and leaves the others.
- R5: Offset 0x20 reads the pin inputs after a two-flop synchroniser.
- R6: Trigger value 1 latches a status bit on a synchronised 0-to-1 transition only.
- R7: Trigger value 2 latches a status bit on a 1-to-0 transition only.
- R8: Trigger value 3 latches a status bit on either transition.
- R9: Trigger value 0, or a pin configured as output, never sets its status bit.
- R10: Writing offset 0x80 clears each status bit written as 1. Bits written 0 keep their value.
- R11: If an edge is detected on a pin in the same cycle that its status bit is cleared, the bit stays set.
- R12: Writing 1s at 0xA0 sets mask bits and at 0xC0 clears them. Both offsets read the mask. irq is high exactly while some status bit is set with its mask bit clear.
- R13: Read data is registered: it is valid on the cycle after bus_rd is sampled. Undecoded offsets read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 9 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 32 | Raw pin inputs |
| pin_out | output | 32 | Output latch |
| pin_oe | output | 32 | Output enable per pin |
| irq | output | 1 | Bank interrupt |

## Verification
Edge detection is tried with rise-only, fall-only and both-edge pins, each driven through a full high-then-low pulse. A rise-only pin that also flags its falling edge, or a fall-only pin that flags its rise, shows that the trigger decode is wrong. Pins with trigger 0, and output pins, are toggled to show that they stay silent. A status clear is timed to land in the same cycle as a fresh edge, which separates edge-wins logic from clear-wins logic. Partial writes to the set, clear and acknowledge registers, with masks that differ from the pending status, show that zero bits are left alone and that irq follows only unmasked status.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int BUS_AW = 9;
  localparam int BUS_DW = 32;

  // register byte offsets
  localparam int OFF_OUT_STS  = 'h00;
  localparam int OFF_IN_STS   = 'h20;
  localparam int OFF_OUT_SET  = 'h40;
  localparam int OFF_OUT_CLR  = 'h60;
  localparam int OFF_INT_STS  = 'h80;
  localparam int OFF_MASK_SET = 'hA0;
  localparam int OFF_MASK_CLR = 'hC0;
  localparam int OFF_CTRL     = 'h100;

  // control word field positions
  localparam int CTL_DIR_BIT = 0;
  localparam int CTL_TRG_LSB = 3;

  typedef enum logic [1:0] {
    TRG_NONE = 2'd0,
    TRG_RISE = 2'd1,
    TRG_FALL = 2'd2,
    TRG_BOTH = 2'd3
  } trig_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= d;
      stage2_q <= stage1_q;
    end
  end

  assign q = stage2_q;
endmodule

// File: rtl/gpio_edge_det.sv
module gpio_edge_det
  import gpio_bank_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NPINS-1:0]      lvl,
  input  logic [NPINS-1:0]      is_input,
  input  logic [NPINS-1:0][1:0] trig,
  output logic [NPINS-1:0]      hit
);
  logic [NPINS-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl;
  end

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic rise, fall, want_rise, want_fall;
    always_comb begin
      rise      = lvl[i] & ~prev_q[i];
      fall      = ~lvl[i] & prev_q[i];
      want_rise = (trig[i] == TRG_RISE) || (trig[i] == TRG_BOTH);
      want_fall = (trig[i] == TRG_FALL) || (trig[i] == TRG_BOTH);
      hit[i]    = is_input[i] & ((want_rise & rise) | (want_fall & fall));
    end
  end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int NPINS  = 32,
  parameter int ADDR_W = BUS_AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  output logic              irq
);
  localparam int WW       = ADDR_W - 2;
  localparam int CTRL_WRD = OFF_CTRL / 4;

  // state
  logic [NPINS-1:0]      out_q, out_d;
  logic [NPINS-1:0]      mask_q, mask_d;
  logic [NPINS-1:0]      sts_q, sts_d;
  logic [NPINS-1:0]      dir_q, dir_d;
  logic [NPINS-1:0][1:0] trig_q, trig_d;
  logic [31:0]           rdata_q, rdata_d;

  logic [NPINS-1:0] lvl;
  logic [NPINS-1:0] hit;

  // address decode
  logic [WW-1:0] word;
  logic [WW-1:0] ctrl_off;
  logic          ctrl_sel;
  logic          wr_out_set, wr_out_clr, wr_sts, wr_mset, wr_mclr;

  gpio_sync #(.W(NPINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(lvl)
  );

  gpio_edge_det #(.NPINS(NPINS)) u_edge (
    .clk(clk), .rst_n(rst_n), .lvl(lvl), .is_input(dir_q),
    .trig(trig_q), .hit(hit)
  );

  always_comb begin
    word       = bus_addr[ADDR_W-1:2];
    ctrl_off   = word - WW'(CTRL_WRD);
    ctrl_sel   = (word >= WW'(CTRL_WRD)) && (ctrl_off < WW'(NPINS)) &&
                 (bus_addr[1:0] == 2'b00);
    wr_out_set = bus_wr && (bus_addr == ADDR_W'(OFF_OUT_SET));
    wr_out_clr = bus_wr && (bus_addr == ADDR_W'(OFF_OUT_CLR));
    wr_sts     = bus_wr && (bus_addr == ADDR_W'(OFF_INT_STS));
    wr_mset    = bus_wr && (bus_addr == ADDR_W'(OFF_MASK_SET));
    wr_mclr    = bus_wr && (bus_addr == ADDR_W'(OFF_MASK_CLR));
  end

  // next state
  always_comb begin
    out_d = out_q;
    if (wr_out_set) out_d = out_d | bus_wdata[NPINS-1:0];
    if (wr_out_clr) out_d = out_d & ~bus_wdata[NPINS-1:0];

    mask_d = mask_q;
    if (wr_mset) mask_d = mask_d | bus_wdata[NPINS-1:0];
    if (wr_mclr) mask_d = mask_d & ~bus_wdata[NPINS-1:0];

    // acknowledge first, then fresh edges on top: edge wins
    sts_d = sts_q;
    if (wr_sts) sts_d = sts_d & ~bus_wdata[NPINS-1:0];
    sts_d = sts_d | hit;

    dir_d  = dir_q;
    trig_d = trig_q;
    for (int i = 0; i < NPINS; i++) begin
      if (bus_wr && ctrl_sel && (ctrl_off == WW'(i))) begin
        dir_d[i]  = bus_wdata[CTL_DIR_BIT];
        trig_d[i] = bus_wdata[CTL_TRG_LSB +: 2];
      end
    end
  end

  // read path
  always_comb begin
    rdata_d = rdata_q;
    if (bus_rd) begin
      rdata_d = '0;
      case (bus_addr)
        ADDR_W'(OFF_OUT_STS),
        ADDR_W'(OFF_OUT_SET),
        ADDR_W'(OFF_OUT_CLR):  rdata_d[NPINS-1:0] = out_q;
        ADDR_W'(OFF_IN_STS):   rdata_d[NPINS-1:0] = lvl;
        ADDR_W'(OFF_INT_STS):  rdata_d[NPINS-1:0] = sts_q;
        ADDR_W'(OFF_MASK_SET),
        ADDR_W'(OFF_MASK_CLR): rdata_d[NPINS-1:0] = mask_q;
        default: begin
          for (int i = 0; i < NPINS; i++) begin
            if (ctrl_sel && (ctrl_off == WW'(i))) begin
              rdata_d[CTL_DIR_BIT]      = dir_q[i];
              rdata_d[CTL_TRG_LSB +: 2] = trig_q[i];
            end
          end
        end
      endcase
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q   <= '0;
      mask_q  <= '1;
      sts_q   <= '0;
      dir_q   <= '1;
      trig_q  <= '0;
      rdata_q <= '0;
    end else begin
      out_q   <= out_d;
      mask_q  <= mask_d;
      sts_q   <= sts_d;
      dir_q   <= dir_d;
      trig_q  <= trig_d;
      rdata_q <= rdata_d;
    end
  end

  assign bus_rdata = rdata_q;
  assign pin_out   = out_q;
  assign pin_oe    = ~dir_q;
  assign irq       = |(sts_q & ~mask_q);
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
  import gpio_bank_pkg::*;
#(
  parameter int NPINS  = 32,
  parameter int ADDR_W = BUS_AW
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [NPINS-1:0]  pin_out,
  input logic [NPINS-1:0]  pin_oe,
  input logic              irq,
  input logic [NPINS-1:0]  int_status
);
  logic wr_set, wr_clr, wr_ack, wr_mask_all;
  assign wr_set      = bus_wr && (bus_addr == ADDR_W'(OFF_OUT_SET));
  assign wr_clr      = bus_wr && (bus_addr == ADDR_W'(OFF_OUT_CLR));
  assign wr_ack      = bus_wr && (bus_addr == ADDR_W'(OFF_INT_STS));
  assign wr_mask_all = bus_wr && (bus_addr == ADDR_W'(OFF_MASK_SET)) &&
                       (bus_wdata[NPINS-1:0] == '1);

  assert_out_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set |=> ((pin_out & $past(bus_wdata[NPINS-1:0])) == $past(bus_wdata[NPINS-1:0])));

  assert_out_clr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> ((pin_out & $past(bus_wdata[NPINS-1:0])) == '0));

  assert_output_pins_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((int_status & ~$past(int_status) & $past(pin_oe)) == '0));

  assert_ack_keeps_zero_bits_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ack |=> ((int_status & $past(int_status) & ~$past(bus_wdata[NPINS-1:0])) ==
                ($past(int_status) & ~$past(bus_wdata[NPINS-1:0]))));

  assert_full_mask_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mask_all |=> !irq);
endmodule

bind gpio_bank gpio_bank_chk #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq),
  .int_status(sts_q)
);

// File: tb/sim_gpio_bank.sv
`timescale 1ns/1ps
module sim_gpio_bank;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr, bus_rd;
  logic [8:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [31:0] pin_in, pin_out, pin_oe;
  logic        irq;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_q;

  always #2 clk = ~clk;

  gpio_bank u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  // monitor: pops expected read data one cycle after each strobe
  always @(posedge clk) rd_q <= bus_rd;

  always @(negedge clk) begin
    if (rd_q === 1'b1) begin
      if (exp_q.size() == 0) begin
        n_run++; n_fail++;
        $display("FAIL R13 unexpected read data %h, expected none", bus_rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_run++;
        if (bus_rdata !== e) begin
          n_fail++;
          $display("FAIL %s read: actual %h expected %h", t, bus_rdata, e);
        end
      end
    end
  end

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_exp(input logic [8:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    exp_q.push_back(e); tag_q.push_back(t);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic chk(input logic [31:0] act, input logic [31:0] e, input string t);
    n_run++;
    if (act !== e) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", t, act, e);
    end
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_wr = 0; bus_rd = 0; bus_addr = '0; bus_wdata = '0;
    pin_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(pin_oe, 32'h0, "R1 pin_oe");
    chk(pin_out, 32'h0, "R1 pin_out");
    chk({31'b0, irq}, 32'h0, "R1 irq");
    rd_exp(9'h080, 32'h0, "R1 status");
    rd_exp(9'h0A0, 32'hFFFF_FFFF, "R1 mask");
    rd_exp(9'h100, 32'h1, "R1 ctrl pin0");
    rd_exp(9'h17C, 32'h1, "R1 ctrl pin31");

    // R2 control word
    wr(9'h114, 32'h0);
    chk(pin_oe, 32'h0000_0020, "R2 pin5 output");
    rd_exp(9'h114, 32'h0, "R2 ctrl pin5 out");
    wr(9'h114, 32'hFFFF_FFFF);
    chk(pin_oe, 32'h0, "R2 pin5 input");
    rd_exp(9'h114, 32'h19, "R2 ctrl pin5 bits kept");

    // R3 / R4 output latch
    wr(9'h040, 32'h0000_00F0);
    rd_exp(9'h000, 32'h0000_00F0, "R3 set");
    wr(9'h040, 32'h0000_0001);
    rd_exp(9'h000, 32'h0000_00F1, "R3 set keeps zeros");
    wr(9'h060, 32'h0000_0030);
    rd_exp(9'h000, 32'h0000_00C1, "R4 clear");
    chk(pin_out, 32'h0000_00C1, "R4 pin_out");

    // R13 undecoded offset
    rd_exp(9'h0E0, 32'h0, "R13 undecoded");

    // R5 input sync
    pin_in = 32'hA5A5_0000;
    settle();
    rd_exp(9'h020, 32'hA5A5_0000, "R5 input status");

    // R6 rising on pin0, unmasked
    wr(9'h100, 32'h09);
    wr(9'h0C0, 32'h1);
    pin_in[0] = 1'b1; settle();
    rd_exp(9'h080, 32'h1, "R6 rise latched");
    chk({31'b0, irq}, 32'h1, "R6 irq");
    wr(9'h080, 32'h1);
    chk({31'b0, irq}, 32'h0, "R10 irq after ack");
    pin_in[0] = 1'b0; settle();
    rd_exp(9'h080, 32'h0, "R6 fall ignored");

    // R7 falling on pin1
    wr(9'h104, 32'h11);
    pin_in[1] = 1'b1; settle();
    rd_exp(9'h080, 32'h0, "R7 rise ignored");
    pin_in[1] = 1'b0; settle();
    rd_exp(9'h080, 32'h2, "R7 fall latched");
    wr(9'h080, 32'h2);

    // R8 both on pin2
    wr(9'h108, 32'h19);
    pin_in[2] = 1'b1; settle();
    rd_exp(9'h080, 32'h4, "R8 rise latched");
    wr(9'h080, 32'h4);
    pin_in[2] = 1'b0; settle();
    rd_exp(9'h080, 32'h4, "R8 fall latched");
    wr(9'h080, 32'h4);

    // R9 trigger none, and output pin
    wr(9'h10C, 32'h01);
    wr(9'h110, 32'h18);
    pin_in[3] = 1'b1; pin_in[4] = 1'b1; settle();
    pin_in[3] = 1'b0; pin_in[4] = 1'b0; settle();
    rd_exp(9'h080, 32'h0, "R9 no status");

    // R10 partial acknowledge
    pin_in[1] = 1'b1; settle(); pin_in[1] = 1'b0; settle();
    pin_in[2] = 1'b1; settle();
    rd_exp(9'h080, 32'h6, "R10 two pending");
    wr(9'h080, 32'h2);
    rd_exp(9'h080, 32'h4, "R10 zero bit kept");

    // R11 edge and acknowledge in the same cycle
    @(negedge clk); pin_in[2] = 1'b0;
    @(negedge clk);
    @(negedge clk); bus_wr = 1'b1; bus_addr = 9'h080; bus_wdata = 32'h4;
    @(negedge clk); bus_wr = 1'b0;
    rd_exp(9'h080, 32'h4, "R11 edge wins");
    wr(9'h080, 32'h4);

    // R12 masking
    pin_in[1] = 1'b1; settle(); pin_in[1] = 1'b0; settle();
    rd_exp(9'h080, 32'h2, "R12 pending masked");
    chk({31'b0, irq}, 32'h0, "R12 irq masked");
    rd_exp(9'h0A0, 32'hFFFF_FFFE, "R12 mask read");
    wr(9'h0C0, 32'h2);
    chk({31'b0, irq}, 32'h1, "R12 irq unmasked");
    rd_exp(9'h0C0, 32'hFFFF_FFFC, "R12 mask read at clear");
    wr(9'h0A0, 32'h2);
    chk({31'b0, irq}, 32'h0, "R12 irq remasked");
    wr(9'h080, 32'hFFFF_FFFF);
    rd_exp(9'h080, 32'h0, "R10 all cleared");

    repeat (3) @(negedge clk);
    chk(exp_q.size(), 0, "R13 read queue drained");
    done = 1;
    summary();
    $finish;
  end
endmodule